// File: doc/BRIEF.md
# Fault-Stepped Refill Set Hint Generator

This block gives miss-handling software a pseudo-random choice of which TLB way (set) to overwrite on a refill. Inside it is a 16-bit linear feedback shift register that moves right by one position each time a translation lookup ends in a fault. It never free-runs, so the sequence of hints depends only on how many faults have happened since reset.

When a fault is signalled, the block takes two things and stores them in registers. The first is the two least significant bits of the shift register, taken before that fault's step. The second is the low four bits of the faulting virtual page number. These two values are packed into a select-register word, with the page index at bits 3:0, the set at bits 5:4, and every other bit cleared. Software reads this word to find the TLB slot it should fill. Between faults, both outputs hold their values.

Top module: `refill_set_hint`

## Requirements
- R1: Reset is synchronous. While `rst` is high on a clock edge, the shift register loads 0xCCCC, `set_hint_o` becomes 0 and `tlb_sel_o` becomes 0.
- R2: Each step works as follows. The feedback bit is the parity (XOR of all bits) of the state ANDed with the tap mask 0x8805. The register moves right by one place and the feedback bit enters bit 15, so the new state is {fb, state[15:1]}.
- R3: The shift register steps exactly once on every clock edge where `fault_i` is high, including consecutive fault cycles. It keeps its value on every edge where `fault_i` is low.
- R4: On a fault edge, `set_hint_o` takes state[1:0] from before that edge's step. The new value is visible in the cycle after the strobe.
- R5: On a fault edge, `tlb_sel_o[3:0]` takes `fault_vpn_i[3:0]`.
- R6: On a fault edge, `tlb_sel_o[5:4]` takes the same two bits as `set_hint_o`, and `tlb_sel_o[31:6]` is written as zero.
- R7: `set_hint_o` and `tlb_sel_o` hold their values on every edge where `fault_i` is low, whatever `fault_vpn_i` does.
- R8: Bits of `fault_vpn_i` above bit 3 have no effect on either output or on the hint sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fault_i | input | 1 | High for one cycle per lookup that ends in a fault or miss |
| fault_vpn_i | input | 19 | Virtual page number of the faulting access |
| set_hint_o | output | 2 | Registered way suggestion for the refill |
| tlb_sel_o | output | 32 | Registered select-register word: index at [3:0], set at [5:4] |

## Verification
The properties assume that `fault_vpn_i` is a known value whenever `fault_i` is high. They also assume that a fault strobe lasting several cycles means several separate faults, one per cycle, and not a single long event. The stimulus changes inputs only on falling clock edges. It drives a defined page number whenever it raises the strobe. In idle gaps it changes `fault_vpn_i` on purpose, to show that the outputs do not follow it. It runs strings of consecutive fault cycles so that the one-step-per-cycle rule is exercised.

// File: rtl/refill_hint_pkg.sv
package refill_hint_pkg;
   localparam int unsigned RH_LFSR_W  = 16;
   localparam logic [15:0] RH_SEED    = 16'hCCCC;
   localparam logic [15:0] RH_TAPS    = 16'h8805;
   localparam int unsigned RH_SET_W   = 2;
   localparam int unsigned RH_IDX_W   = 4;
   localparam int unsigned RH_VPN_W   = 19;
   localparam int unsigned RH_SEL_W   = 32;
endpackage

// File: rtl/rh_lfsr.sv
module rh_lfsr #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] SEED = 16'hCCCC,
   parameter logic [W-1:0] TAPS = 16'h8805
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   if (W < 2) begin : g_bad_width
      $error("rh_lfsr: width must be at least 2");
   end
   if (TAPS == '0) begin : g_bad_taps
      $error("rh_lfsr: tap mask must not be zero");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("rh_lfsr: seed of zero locks the register");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] tapped;
   logic         fb;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign tapped[i] = state_q[i];
      end else begin : g_off
         assign tapped[i] = 1'b0;
      end
   end

   assign fb = ^tapped;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= {fb, state_q[W-1:1]};
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/rh_sel_pack.sv
module rh_sel_pack #(
   parameter int unsigned VPN_W = 19,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned SET_W = 2,
   parameter int unsigned SEL_W = 32
) (
   input  logic [VPN_W-1:0] vpn_i,
   input  logic [SET_W-1:0] set_i,
   output logic [SEL_W-1:0] word_o
);
   localparam int unsigned SET_LSB = IDX_W;

   if (IDX_W > VPN_W) begin : g_bad_idx
      $error("rh_sel_pack: index wider than page number");
   end
   if (IDX_W + SET_W > SEL_W) begin : g_bad_sel
      $error("rh_sel_pack: fields do not fit the select word");
   end

   always_comb begin
      word_o                     = '0;
      word_o[IDX_W-1:0]          = vpn_i[IDX_W-1:0];
      word_o[SET_LSB +: SET_W]   = set_i;
   end
endmodule

// File: rtl/refill_set_hint.sv
module refill_set_hint
   import refill_hint_pkg::*;
#(
   parameter int unsigned       LFSR_W = RH_LFSR_W,
   parameter logic [LFSR_W-1:0] SEED   = RH_SEED,
   parameter logic [LFSR_W-1:0] TAPS   = RH_TAPS,
   parameter int unsigned       SET_W  = RH_SET_W,
   parameter int unsigned       IDX_W  = RH_IDX_W,
   parameter int unsigned       VPN_W  = RH_VPN_W,
   parameter int unsigned       SEL_W  = RH_SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fault_i,
   input  logic [VPN_W-1:0] fault_vpn_i,
   output logic [SET_W-1:0] set_hint_o,
   output logic [SEL_W-1:0] tlb_sel_o
);
   if (SET_W > LFSR_W) begin : g_bad_set
      $error("refill_set_hint: set field wider than the shift register");
   end

   logic [LFSR_W-1:0] lfsr_state;
   logic [SET_W-1:0]  set_now;
   logic [SEL_W-1:0]  sel_next;
   logic [SET_W-1:0]  hint_q;
   logic [SEL_W-1:0]  sel_q;

   rh_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
      .clk     (clk),
      .rst     (rst),
      .step_i  (fault_i),
      .state_o (lfsr_state)
   );

   // hint is taken from the state before this fault's step
   assign set_now = lfsr_state[SET_W-1:0];

   rh_sel_pack #(.VPN_W(VPN_W), .IDX_W(IDX_W), .SET_W(SET_W), .SEL_W(SEL_W)) u_pack (
      .vpn_i  (fault_vpn_i),
      .set_i  (set_now),
      .word_o (sel_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hint_q <= '0;
         sel_q  <= '0;
      end else if (fault_i) begin
         hint_q <= set_now;
         sel_q  <= sel_next;
      end
   end

   assign set_hint_o = hint_q;
   assign tlb_sel_o  = sel_q;
endmodule

// File: rtl/refill_set_hint_chk.sv
module refill_set_hint_chk #(
   parameter int unsigned       LFSR_W = 16,
   parameter logic [LFSR_W-1:0] TAPS   = 16'h8805,
   parameter int unsigned       SET_W  = 2,
   parameter int unsigned       IDX_W  = 4,
   parameter int unsigned       VPN_W  = 19,
   parameter int unsigned       SEL_W  = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              fault_i,
   input logic [VPN_W-1:0]  fault_vpn_i,
   input logic [LFSR_W-1:0] lfsr_state,
   input logic [SET_W-1:0]  set_hint_o,
   input logic [SEL_W-1:0]  tlb_sel_o
);
   logic [LFSR_W-1:0] exp_next;
   always_comb begin
      exp_next = {^(lfsr_state & TAPS), lfsr_state[LFSR_W-1:1]};
   end

   assert_lfsr_step_R2: assert property (@(posedge clk) disable iff (rst)
      fault_i |=> lfsr_state == $past(exp_next));

   assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !fault_i |=> $stable(lfsr_state));

   assert_hint_pre_step_R4: assert property (@(posedge clk) disable iff (rst)
      fault_i |=> set_hint_o == $past(lfsr_state[SET_W-1:0]));

   assert_sel_index_R5: assert property (@(posedge clk) disable iff (rst)
      fault_i |=> tlb_sel_o[IDX_W-1:0] == $past(fault_vpn_i[IDX_W-1:0]));

   assert_sel_set_R6: assert property (@(posedge clk) disable iff (rst)
      fault_i |=> tlb_sel_o[IDX_W +: SET_W] == set_hint_o);

   assert_sel_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
      fault_i |=> (tlb_sel_o >> (IDX_W + SET_W)) == '0);

   assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !fault_i |=> $stable(set_hint_o) && $stable(tlb_sel_o));
endmodule

bind refill_set_hint refill_set_hint_chk #(
   .LFSR_W(LFSR_W), .TAPS(TAPS), .SET_W(SET_W),
   .IDX_W(IDX_W), .VPN_W(VPN_W), .SEL_W(SEL_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .fault_i     (fault_i),
   .fault_vpn_i (fault_vpn_i),
   .lfsr_state  (lfsr_state),
   .set_hint_o  (set_hint_o),
   .tlb_sel_o   (tlb_sel_o)
);

// File: tb/refill_set_hint_tb.sv
module refill_set_hint_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fault_i = 1'b0;
   logic [18:0] fault_vpn_i = '0;
   logic [1:0]  set_hint_o;
   logic [31:0] tlb_sel_o;

   int n_checks = 0;
   int n_fails  = 0;

   logic [15:0] m_lfsr;
   logic [1:0]  m_hint;
   logic [31:0] m_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   refill_set_hint u_dut (
      .clk         (clk),
      .rst         (rst),
      .fault_i     (fault_i),
      .fault_vpn_i (fault_vpn_i),
      .set_hint_o  (set_hint_o),
      .tlb_sel_o   (tlb_sel_o)
   );

   function automatic logic [15:0] model_step(input logic [15:0] s);
      logic fb;
      fb = ^(s & 16'h8805);
      return {fb, s[15:1]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_fault(input logic [18:0] vpn);
      m_hint = m_lfsr[1:0];
      m_sel  = {26'b0, m_hint, vpn[3:0]};
      m_lfsr = model_step(m_lfsr);
   endtask

   // one isolated fault, result checked in the following cycle
   task automatic one_fault(input logic [18:0] vpn, input string req);
      fault_i     = 1'b1;
      fault_vpn_i = vpn;
      model_fault(vpn);
      @(negedge clk);
      fault_i = 1'b0;
      check({req, " hint"}, {30'b0, set_hint_o}, {30'b0, m_hint});
      check({req, " sel"}, tlb_sel_o, m_sel);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      fault_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_lfsr = 16'hCCCC;
      m_hint = '0;
      m_sel  = '0;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 hint after reset", {30'b0, set_hint_o}, 32'h0);
      check("R1 sel after reset", tlb_sel_o, 32'h0);
      // seed 0xCCCC: first hint 0, second (0xE666) hint 2
      one_fault(19'h0000A, "R1 first fault from seed");
      check("R1 first hint value", {30'b0, set_hint_o}, 32'd0);
      one_fault(19'h00003, "R2 second fault");
      check("R2 second hint value", {30'b0, set_hint_o}, 32'd2);
   endtask

   task automatic t_sequence();
      for (int i = 0; i < 40; i++) begin
         one_fault(19'((i * 7) + 3), "R2 R4 R5 R6 sequence");
         @(negedge clk);
      end
   endtask

   task automatic t_idle_hold();
      one_fault(19'h00005, "R7 pre-idle fault");
      for (int i = 0; i < 12; i++) begin
         fault_vpn_i = 19'(i * 13 + 1);
         @(negedge clk);
         check("R7 hint holds", {30'b0, set_hint_o}, {30'b0, m_hint});
         check("R7 sel holds", tlb_sel_o, m_sel);
      end
      // LFSR must not have moved during the gap
      one_fault(19'h0000F, "R3 after idle gap");
   endtask

   task automatic t_back_to_back();
      fault_i = 1'b1;
      for (int i = 0; i < 16; i++) begin
         fault_vpn_i = 19'(i + 16'h100);
         model_fault(fault_vpn_i);
         @(negedge clk);
         check("R3 consecutive hint", {30'b0, set_hint_o}, {30'b0, m_hint});
         check("R3 consecutive sel", tlb_sel_o, m_sel);
      end
      fault_i = 1'b0;
   endtask

   task automatic t_high_bits();
      one_fault(19'h7FFF9, "R8 high bits set");
      check("R8 sel upper zero", {26'b0, tlb_sel_o[31:6]} >> 0, 32'h0);
      one_fault(19'h00009, "R8 high bits clear");
      one_fault(19'h55550, "R8 alternating high bits");
   endtask

   task automatic t_midrun_reset();
      for (int i = 0; i < 5; i++) one_fault(19'(i), "R3 pre-reset run");
      do_reset();
      check("R1 hint after midrun reset", {30'b0, set_hint_o}, 32'h0);
      check("R1 sel after midrun reset", tlb_sel_o, 32'h0);
      one_fault(19'h00004, "R1 restart from seed");
      one_fault(19'h00004, "R1 restart second");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_sequence();
      t_idle_hold();
      t_back_to_back();
      t_high_bits();
      t_midrun_reset();
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule